// File: doc/BRIEF.md
# ADC Output Overload Flag and Startup Mute

This block sits behind the decimation chain of a stereo audio converter. It watches each sample word that the chain delivers, one left and one right word per sample period, and raises an overload flag when either channel's magnitude passes a level about 1.16 dB under digital full scale. The flag then stays high for a fixed number of sample periods. Each new overload starts that interval again, so the flag only drops after a quiet interval of full length.

The block also produces an enable for the serial data output. After reset, and after a restart pulse that marks recovery from power-down or a clock start, the enable stays low until the filters have had time to settle. That wait is a short count of sample periods when the DC-cancellation filter is off and a much longer count when it is on. Overloads seen during that wait are ignored. If the filter setting changes while the wait is running, the remaining wait can get longer but never shorter. Time is counted in pulses of a sample-rate tick input.

Top module: `adc_out_guard`

## Requirements
- R1: While reset is asserted, `ovl_flag` and `sdo_en` are both 0.
- R2: A valid sample whose left word, read as two's complement, has a magnitude above THR = floor((2^(W-1)-1)*7/8) (458751 for W=20) sets `ovl_flag` at the clock edge that accepts it. A magnitude equal to THR does not set it.
- R3: The right word is judged in the same way. Either channel on its own is enough to set the flag.
- R4: Sample words presented while `smp_vld` is 0 have no effect on `ovl_flag`.
- R5: The most negative code is read as the largest positive magnitude. It does not wrap to zero, so it counts as an overload.
- R6: After the last overload, `ovl_flag` stays 1 until HOLD_PER (512) `fs_tick` pulses have been accepted. It falls at the edge that accepts the last of those pulses.
- R7: An overload while the flag is already high restarts the full HOLD_PER count.
- R8: After reset is released, the mute length is loaded within three clock cycles. `sdo_en` stays 0 until MUTE_SHORT (1024) `fs_tick` pulses have been accepted when `dcf_en` is 0, and it rises at the edge that accepts the last of them.
- R9: With `dcf_en` at 1 the mute lasts MUTE_LONG (12288) ticks. A `restart` pulse drives `sdo_en` to 0 at the next edge and starts a new mute, whose length follows `dcf_en` one cycle later.
- R10: A change of `dcf_en` during a mute sets the remaining count to the larger of the remaining count and the newly selected length, and no tick is taken in that cycle. A change of `dcf_en` while no mute is running leaves `sdo_en` at 1.
- R11: While `sdo_en` is 0, overload samples do not set `ovl_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fs_tick | input | 1 | One-cycle pulse, once per sample period |
| smp_vld | input | 1 | Left and right words are valid this cycle |
| smp_left | input | SMP_W | Left sample, two's complement |
| smp_right | input | SMP_W | Right sample, two's complement |
| dcf_en | input | 1 | DC-cancellation filter enabled; selects the long mute |
| restart | input | 1 | Pulse marking recovery from power-down or a clock start |
| ovl_flag | output | 1 | Overload indication, held for HOLD_PER ticks |
| sdo_en | output | 1 | 1 when the serial data output may carry data, 0 when it is forced low |

## Verification
The case hardest to reach is a change of the filter setting in the middle of a long mute. To reach it, the stimulus must count thousands of ticks to a known remaining value and then flip `dcf_en`. Once the flip falls where the remaining count is above the short length, which must not shorten the wait. Once it falls near the end of the wait, where the count must jump up to the newly selected length. A reference model in the bench follows the remaining count tick by tick, so a wait that ends one tick early or one tick late is caught. Samples of exactly the threshold, one code above it, and the most negative code are applied to each channel. Some of them are applied during the mute, some with `smp_vld` low, and some while the flag is already high.

// File: rtl/adc_guard_pkg.sv
package adc_guard_pkg;

  localparam int unsigned NCH = 2;

  // Level about 1.16 dB under full scale: full-scale magnitude times 7/8.
  function automatic longint unsigned near_fs_thr(input int unsigned w);
    longint unsigned fs;
    fs = (64'd1 << (w - 1)) - 64'd1;
    return (fs * 64'd7) >> 3;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/agd_level_cmp.sv
module agd_level_cmp #(
  parameter int unsigned W   = 20,
  parameter logic [W-2:0] THR = '0
) (
  input  logic [W-1:0] smp,
  output logic         over
);

  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] neg;
  logic [W-2:0] mag;

  always_comb begin
    neg = -smp;
    if (!smp[W-1]) begin
      mag = smp[W-2:0];
    end else if (smp == MOST_NEG) begin
      mag = '1;                       // saturate instead of wrapping
    end else begin
      mag = neg[W-2:0];
    end
    over = (mag > THR);
  end

endmodule

// File: rtl/agd_hold_timer.sv
module agd_hold_timer #(
  parameter int unsigned HOLD_PER = 512,
  parameter int unsigned CW       = $clog2(HOLD_PER + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  output logic active
);

  localparam logic [CW-1:0] LOAD = CW'(HOLD_PER);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (trig) begin
      cnt_d = LOAD;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign active = (cnt_q != '0);

endmodule

// File: rtl/agd_start_mute.sv
module agd_start_mute #(
  parameter int unsigned MUTE_SHORT = 1024,
  parameter int unsigned MUTE_LONG  = 12288,
  parameter int unsigned CW         = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          restart,
  input  logic          dcf_en,
  output logic          mute,
  output logic          pend_o,
  output logic [CW-1:0] cnt_o
);

  localparam logic [CW-1:0] LEN_S = CW'(MUTE_SHORT);
  localparam logic [CW-1:0] LEN_L = CW'(MUTE_LONG);

  logic          pend_q, pend_d;
  logic          dcf_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] len_sel;
  logic          dcf_chg;

  always_comb begin
    len_sel = dcf_en ? LEN_L : LEN_S;
    dcf_chg = (dcf_en != dcf_q);
    cnt_d   = cnt_q;
    if (pend_q) begin
      cnt_d = len_sel;
    end else if ((cnt_q != '0) && dcf_chg) begin
      cnt_d = (cnt_q > len_sel) ? cnt_q : len_sel;
    end else if (tick && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
    pend_d = restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b1;
      cnt_q  <= '0;
      dcf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
      dcf_q  <= dcf_en;
    end
  end

  assign mute   = pend_q | (cnt_q != '0);
  assign pend_o = pend_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/adc_out_guard.sv
module adc_out_guard
  import adc_guard_pkg::*;
#(
  parameter int unsigned SMP_W      = 20,
  parameter int unsigned HOLD_PER   = 512,
  parameter int unsigned MUTE_SHORT = 1024,
  parameter int unsigned MUTE_LONG  = 12288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fs_tick,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp_left,
  input  logic [SMP_W-1:0] smp_right,
  input  logic             dcf_en,
  input  logic             restart,
  output logic             ovl_flag,
  output logic             sdo_en
);

  localparam logic [SMP_W-2:0] THR   = (SMP_W-1)'(near_fs_thr(SMP_W));
  localparam int unsigned      HOLD_W = $clog2(HOLD_PER + 1);
  localparam int unsigned      MUTE_W = $clog2(max_u(MUTE_SHORT, MUTE_LONG) + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sync[1];

  logic [SMP_W-1:0] ch_smp  [NCH];
  logic [NCH-1:0]   ch_over;

  assign ch_smp[0] = smp_left;
  assign ch_smp[1] = smp_right;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    agd_level_cmp #(.W(SMP_W), .THR(THR)) u_cmp (
      .smp  (ch_smp[c]),
      .over (ch_over[c])
    );
  end

  logic              muting;
  logic              mute_pend;
  logic [MUTE_W-1:0] mute_cnt;
  logic [31:0]       mute_cnt32;
  logic              ovl_hit;

  assign ovl_hit = smp_vld & (|ch_over) & ~muting;

  agd_hold_timer #(.HOLD_PER(HOLD_PER), .CW(HOLD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick   (fs_tick),
    .trig   (ovl_hit),
    .active (ovl_flag)
  );

  agd_start_mute #(.MUTE_SHORT(MUTE_SHORT), .MUTE_LONG(MUTE_LONG), .CW(MUTE_W)) u_mute (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .tick    (fs_tick),
    .restart (restart),
    .dcf_en  (dcf_en),
    .mute    (muting),
    .pend_o  (mute_pend),
    .cnt_o   (mute_cnt)
  );

  assign mute_cnt32 = 32'(mute_cnt);
  assign sdo_en     = ~muting;

endmodule

// File: rtl/adc_out_guard_chk.sv
module adc_out_guard_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fs_tick,
  input logic        smp_vld,
  input logic        restart,
  input logic        ovl_flag,
  input logic        sdo_en,
  input logic        mute_pend,
  input logic [31:0] mute_cnt32
);

  // R2
  ovl_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_flag) |-> $past(smp_vld));

  // R6
  ovl_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovl_flag) |-> $past(fs_tick));

  // R11
  mute_blocks_ovl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sdo_en && !ovl_flag) |=> !ovl_flag);

  // R8
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_en) |-> $past(fs_tick));

  // R9
  restart_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sdo_en);

  // R10
  gate_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en && !restart) |=> sdo_en);

  // R10
  no_shorten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mute_cnt32 != 0) && !fs_tick && !mute_pend) |=> (mute_cnt32 >= $past(mute_cnt32)));

endmodule

bind adc_out_guard adc_out_guard_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fs_tick    (fs_tick),
  .smp_vld    (smp_vld),
  .restart    (restart),
  .ovl_flag   (ovl_flag),
  .sdo_en     (sdo_en),
  .mute_pend  (mute_pend),
  .mute_cnt32 (mute_cnt32)
);

// File: tb/adc_out_guard_tb.sv
module adc_out_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W      = 20;
  localparam int HOLD   = 512;
  localparam int M_S    = 1024;
  localparam int M_L    = 12288;
  localparam int THR_B  = ((1 << (W - 1)) - 1) * 7 / 8;   // 458751

  logic         clk;
  logic         rst_n;
  logic         fs_tick;
  logic         smp_vld;
  logic [W-1:0] smp_left;
  logic [W-1:0] smp_right;
  logic         dcf_en;
  logic         restart;
  logic         ovl_flag;
  logic         sdo_en;

  adc_out_guard u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_tick   (fs_tick),
    .smp_vld   (smp_vld),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .dcf_en    (dcf_en),
    .restart   (restart),
    .ovl_flag  (ovl_flag),
    .sdo_en    (sdo_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    bit    ovl;
    bit    en;
    string tag;
  } exp_t;

  exp_t  exp_q[$];
  int    n_chk  = 0;
  int    n_fail = 0;
  string cur_tag = "R1";

  // reference state
  int m_hold, m_mute;
  bit m_pend, m_dcf;

  function automatic bit over_b(input logic [W-1:0] x);
    int s;
    s = int'($signed(x));
    if (s < 0) s = -s;
    return s > THR_B;
  endfunction

  function automatic int len_b(input bit d);
    return d ? M_L : M_S;
  endfunction

  task automatic step(input bit t, input bit v, input logic [W-1:0] l,
                      input logic [W-1:0] r, input bit d, input bit rs);
    exp_t e;
    bit   act, hit;
    @(negedge clk);
    fs_tick = t; smp_vld = v; smp_left = l; smp_right = r; dcf_en = d; restart = rs;
    act = m_pend || (m_mute != 0);
    hit = v && !act && (over_b(l) || over_b(r));
    if (hit) m_hold = HOLD;
    else if (t && m_hold != 0) m_hold--;
    if (m_pend) m_mute = len_b(d);
    else if (m_mute != 0 && d != m_dcf) m_mute = (m_mute > len_b(d)) ? m_mute : len_b(d);
    else if (t && m_mute != 0) m_mute--;
    m_pend = rs;
    m_dcf  = d;
    e.ovl = (m_hold != 0);
    e.en  = !(m_pend || (m_mute != 0));
    e.tag = cur_tag;
    exp_q.push_back(e);
  endtask

  bit dcf_b = 1'b0;

  // n sample periods, two cycles each; optional sample on the tick cycle
  task automatic tk(input int n, input bit v, input logic [W-1:0] l, input logic [W-1:0] r);
    for (int i = 0; i < n; i++) begin
      step(1'b1, v, l, r, dcf_b, 1'b0);
      step(1'b0, 1'b0, '0, '0, dcf_b, 1'b0);
    end
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_chk++;
        if (ovl_flag !== e.ovl || sdo_en !== e.en) begin
          n_fail++;
          $display("FAIL %s: ovl_flag=%0b sdo_en=%0b expected ovl_flag=%0b sdo_en=%0b at %0t",
                   e.tag, ovl_flag, sdo_en, e.ovl, e.en, $time);
        end
      end
    end
  end

  task automatic direct(input string tag, input bit ovl_e, input bit en_e);
    n_chk++;
    if (ovl_flag !== ovl_e || sdo_en !== en_e) begin
      n_fail++;
      $display("FAIL %s: ovl_flag=%0b sdo_en=%0b expected ovl_flag=%0b sdo_en=%0b",
               tag, ovl_flag, sdo_en, ovl_e, en_e);
    end
  endtask

  localparam logic [W-1:0] V_MAX   = W'((1 << (W - 1)) - 1);
  localparam logic [W-1:0] V_THR   = W'(THR_B);
  localparam logic [W-1:0] V_THR1  = W'(THR_B + 1);
  localparam logic [W-1:0] V_NTHR  = W'(-THR_B);
  localparam logic [W-1:0] V_NTHR1 = W'(-(THR_B + 1));
  localparam logic [W-1:0] V_MIN   = {1'b1, {(W-1){1'b0}}};

  initial begin
    rst_n = 1'b0; fs_tick = 0; smp_vld = 0; smp_left = '0; smp_right = '0;
    dcf_en = 0; restart = 0;
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      direct("R1", 1'b0, 1'b0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    direct("R8", 1'b0, 1'b0);
    m_hold = 0; m_mute = M_S; m_pend = 0; m_dcf = 0;

    // R11: overloads during the startup mute are ignored
    cur_tag = "R11";
    tk(1000, 1'b1, V_MAX, V_MIN);
    // R8: short mute runs out at exactly 1024 ticks
    cur_tag = "R8";
    tk(30, 1'b0, '0, '0);

    // R2: threshold itself is not an overload, one above is
    cur_tag = "R2";
    step(0, 1, V_THR, '0, dcf_b, 0);
    step(0, 1, V_NTHR, V_THR, dcf_b, 0);
    // R4: invalid words ignored
    cur_tag = "R4";
    step(0, 0, V_MAX, V_MIN, dcf_b, 0);
    step(0, 0, V_MIN, V_MAX, dcf_b, 0);
    tk(3, 1'b0, '0, '0);
    cur_tag = "R2";
    step(0, 1, V_THR1, '0, dcf_b, 0);
    // R6: hold runs out after 512 ticks
    cur_tag = "R6";
    tk(520, 1'b0, '0, '0);
    // R3: right channel alone
    cur_tag = "R3";
    step(0, 1, '0, V_NTHR1, dcf_b, 0);
    tk(300, 1'b0, '0, '0);
    // R5 / R7: most negative code retriggers the hold
    cur_tag = "R5";
    step(0, 1, V_MIN, '0, dcf_b, 0);
    cur_tag = "R7";
    tk(520, 1'b0, '0, '0);

    // R9: restart with the DC filter on gives the long mute
    cur_tag = "R9";
    dcf_b = 1'b1;
    step(0, 0, '0, '0, dcf_b, 1);
    tk(7288, 1'b0, '0, '0);
    // R10: dropping to the short length with 5000 left keeps 5000
    cur_tag = "R10";
    dcf_b = 1'b0;
    tk(4712, 1'b0, '0, '0);
    // R10: switching on near the end raises the count to the long length
    dcf_b = 1'b1;
    tk(12000, 1'b1, V_MAX, '0);
    // R10: switching off with under 1024 left raises it to 1024
    dcf_b = 1'b0;
    tk(1030, 1'b0, '0, '0);
    // R10: changes outside a mute leave the gate open
    dcf_b = 1'b1;
    tk(3, 1'b0, '0, '0);
    dcf_b = 1'b0;
    tk(3, 1'b0, '0, '0);
    cur_tag = "R3";
    step(0, 1, V_THR, V_MIN, dcf_b, 0);
    tk(4, 1'b0, '0, '0);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule